// File: doc/BRIEF.md
# Single-Clock Queue with Selectable Read Timing

A first-in first-out queue in which writes and reads share one clock. The write side offers a data word with a request strobe and reports when it can accept one. The read side reports when an entry is waiting and accepts a request strobe to remove it. An exact occupancy count is available at all times. A compile-time switch picks the read timing. In show-ahead mode the oldest entry is already on the read data port whenever one is waiting. In registered mode the data port is loaded on the edge that removes an entry.

Any depth may be configured, including odd sizes such as 3 or 5, and zero. Both pointers wrap by comparing against the last slot, so no power-of-two rounding takes place and the usable depth is exactly the parameter. A depth of zero builds no storage, and both sides stay not-ready forever.

Occupancy is tracked by a three-state controller. `Q_EMPTY` means no entries, `Q_PART` means some but not all slots are used, and `Q_FULL` means every slot is used. The named transitions are as follows:
- FILL_FIRST: `Q_EMPTY`→`Q_PART` on a lone write.
- FILL_LAST: `Q_PART`→`Q_FULL` on a lone write at depth−1.
- DRAIN_LAST: `Q_PART`→`Q_EMPTY` on a lone read at occupancy 1.
- DRAIN_FIRST: `Q_FULL`→`Q_PART` on a lone read.
- FILL_ONE: `Q_EMPTY`→`Q_FULL` at depth 1.
- DRAIN_ONE: `Q_FULL`→`Q_EMPTY` at depth 1.

A simultaneous read and write never changes the state.

Top module: `shq_fifo`

## Requirements
- R1: `rd_ok` is high exactly when `fill` is greater than zero, and `wr_ok` is high exactly when `fill` is less than DEPTH.
- R2: A write is taken only in a cycle with `wr_req` and `wr_ok` both high; a write request while `wr_ok` is low changes neither `fill` nor the queue contents.
- R3: A read is taken only in a cycle with `rd_req` and `rd_ok` both high; a read request while `rd_ok` is low changes neither `fill` nor the read data.
- R4: After each clock edge, `fill` equals its previous value plus one for a taken write and minus one for a taken read, so both in one cycle leave it unchanged.
- R5: A synchronous active-high `rst` sets `fill` to 0, so `rd_ok` is low from the first edge with `rst` high onward, and in registered mode sets `rd_dat` to 0.
- R6: With SHOW_AHEAD=1, whenever `rd_ok` is high, `rd_dat` equals the oldest entry, with no read request needed.
- R7: With SHOW_AHEAD=0, `rd_dat` takes the oldest entry on the edge that ends a cycle with a taken read, and otherwise keeps its value.
- R8: Entries leave in the order they were written, including across pointer wrap at a depth that is not a power of two.
- R9: With DEPTH=0, `wr_ok`, `rd_ok` and `fill` stay 0 at all times.
- R10: `fill` reports the exact entry count up to and including DEPTH, and reads DEPTH when the queue is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_dat | input | WIDTH | Data to enqueue |
| wr_req | input | 1 | Write request |
| wr_ok | output | 1 | Queue can take a write |
| rd_dat | output | WIDTH | Oldest entry (show-ahead) or last dequeued entry (registered) |
| rd_req | input | 1 | Read request |
| rd_ok | output | 1 | Queue holds at least one entry |
| fill | output | LW | Current occupancy, 0 to DEPTH |

## Verification
`fill`, `rd_ok` and `wr_ok` reflect a taken transfer one edge after the cycle in which it was requested. Show-ahead read data follows the new head in that same cycle, with no extra delay. Registered read data appears one edge after the cycle in which the read was taken. The bench drives inputs on the falling edge and updates its queue model on the rising edge. It then compares every output of every configuration on the next falling edge, so each result is sampled in the first cycle it is due and again on every later cycle.

// File: rtl/shq_pkg.sv
package shq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_t;

    // bits needed for a count from 0 to d inclusive (at least 1)
    function automatic int lvl_bits(input int d);
        return (d < 1) ? 1 : $clog2(d + 1);
    endfunction

    // bits needed to index d slots (at least 1)
    function automatic int ptr_bits(input int d);
        return (d <= 1) ? 1 : $clog2(d);
    endfunction

endpackage

// File: rtl/shq_ptr.sv
module shq_ptr #(
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] ptr_q;

    // wrap by comparison against the last slot, no masking
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (adv) begin
            if (ptr_q == LAST) ptr_q <= '0;
            else               ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/shq_store.sv
module shq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/shq_ctrl.sv
module shq_ctrl
    import shq_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [LW-1:0] fill
);
    localparam logic [LW-1:0] TOP     = LW'(DEPTH);
    localparam logic [LW-1:0] NEAR    = LW'(DEPTH - 1);
    localparam bit            SINGLE  = (DEPTH == 1);

    qstate_t       st_q, st_d;
    logic [LW-1:0] lvl_q;
    logic          only_w, only_r;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= Q_EMPTY;
        else     st_q <= st_d;
    end

    // occupancy counter
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (only_w) begin
            lvl_q <= lvl_q + 1'b1;
        end else if (only_r) begin
            lvl_q <= lvl_q - 1'b1;
        end
    end

    assign only_w = wr_acc & ~rd_acc;
    assign only_r = rd_acc & ~wr_acc;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_EMPTY: begin
                if (only_w) st_d = SINGLE ? Q_FULL : Q_PART;      // FILL_ONE / FILL_FIRST
            end
            Q_PART: begin
                if (only_w && lvl_q == NEAR)  st_d = Q_FULL;      // FILL_LAST
                else if (only_r && lvl_q == LW'(1)) st_d = Q_EMPTY; // DRAIN_LAST
            end
            Q_FULL: begin
                if (only_r) st_d = SINGLE ? Q_EMPTY : Q_PART;     // DRAIN_ONE / DRAIN_FIRST
            end
            default: st_d = Q_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        wr_ok = 1'b0;
        rd_ok = 1'b0;
        unique case (st_q)
            Q_EMPTY: begin wr_ok = 1'b1; rd_ok = 1'b0; end
            Q_PART:  begin wr_ok = 1'b1; rd_ok = 1'b1; end
            Q_FULL:  begin wr_ok = 1'b0; rd_ok = 1'b1; end
            default: begin wr_ok = 1'b0; rd_ok = 1'b0; end
        endcase
        wr_acc = wr_req & wr_ok;
        rd_acc = rd_req & rd_ok;
    end

    assign fill = (lvl_q > TOP) ? TOP : lvl_q;
endmodule

// File: rtl/shq_fifo.sv
module shq_fifo
    import shq_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int DEPTH      = 5,
    parameter bit SHOW_AHEAD = 1'b1,
    parameter int LW         = shq_pkg::lvl_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wr_dat,
    input  logic             wr_req,
    output logic             wr_ok,
    output logic [WIDTH-1:0] rd_dat,
    input  logic             rd_req,
    output logic             rd_ok,
    output logic [LW-1:0]    fill
);
    localparam int PW = ptr_bits(DEPTH);

    generate
        if (DEPTH == 0) begin : g_none
            assign wr_ok  = 1'b0;
            assign rd_ok  = 1'b0;
            assign fill   = '0;
            assign rd_dat = '0;
        end else begin : g_queue
            logic             wacc, racc;
            logic [PW-1:0]    wptr, rptr;
            logic [WIDTH-1:0] head;

            shq_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_ctrl (
                .clk    (clk),
                .rst    (rst),
                .wr_req (wr_req),
                .rd_req (rd_req),
                .wr_acc (wacc),
                .rd_acc (racc),
                .wr_ok  (wr_ok),
                .rd_ok  (rd_ok),
                .fill   (fill)
            );

            shq_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
                .clk (clk), .rst (rst), .adv (wacc), .ptr (wptr)
            );

            shq_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
                .clk (clk), .rst (rst), .adv (racc), .ptr (rptr)
            );

            shq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_store (
                .clk   (clk),
                .we    (wacc),
                .waddr (wptr),
                .wdata (wr_dat),
                .raddr (rptr),
                .rdata (head)
            );

            if (SHOW_AHEAD) begin : g_ahead
                assign rd_dat = head;
            end else begin : g_reg
                logic [WIDTH-1:0] rd_q;
                always_ff @(posedge clk) begin
                    if (rst)       rd_q <= '0;
                    else if (racc) rd_q <= head;
                end
                assign rd_dat = rd_q;
            end
        end
    endgenerate
endmodule

// File: rtl/shq_fifo_chk.sv
module shq_fifo_chk #(
    parameter int WIDTH      = 8,
    parameter int DEPTH      = 5,
    parameter bit SHOW_AHEAD = 1'b1,
    parameter int LW         = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] wr_dat,
    input logic             wr_req,
    input logic             wr_ok,
    input logic [WIDTH-1:0] rd_dat,
    input logic             rd_req,
    input logic             rd_ok,
    input logic [LW-1:0]    fill
);
    localparam logic [LW:0] TOPX = (LW+1)'(DEPTH);

    p_rdok_level_r1: assert property (@(posedge clk) disable iff (rst)
        rd_ok == (fill != '0));

    p_wrok_level_r1: assert property (@(posedge clk) disable iff (rst)
        wr_ok == ({1'b0, fill} < TOPX));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        {1'b0, fill} <= TOPX);

    p_level_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> fill == LW'($past(fill) + LW'($past(wr_req && wr_ok))
                                         - LW'($past(rd_req && rd_ok))));

    p_reset_clear_r5: assert property (@(posedge clk)
        rst |=> (fill == '0 && !rd_ok));

    generate
        if (!SHOW_AHEAD && DEPTH > 0) begin : g_reg
            p_hold_r7: assert property (@(posedge clk) disable iff (rst)
                !(rd_req && rd_ok) |=> $stable(rd_dat));
        end
        if (DEPTH == 0) begin : g_zero
            p_never_ready_r9: assert property (@(posedge clk)
                !wr_ok && !rd_ok && fill == '0);
        end
    endgenerate
endmodule

bind shq_fifo shq_fifo_chk #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .SHOW_AHEAD(SHOW_AHEAD), .LW(LW)
) u_chk (
    .clk(clk), .rst(rst), .wr_dat(wr_dat), .wr_req(wr_req), .wr_ok(wr_ok),
    .rd_dat(rd_dat), .rd_req(rd_req), .rd_ok(rd_ok), .fill(fill)
);

// File: tb/sim_shq_fifo.sv
module sim_shq_fifo;
    localparam int PERIOD = 10;
    localparam int NCYC   = 2500;
    localparam int DA     = 5;
    localparam int DB     = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wr_dat = '0;
    logic       wr_req = 1'b0;
    logic       rd_req = 1'b0;

    logic       a_wok, a_rok, b_wok, b_rok, c_wok, c_rok;
    logic [7:0] a_dat, b_dat, c_dat;
    logic [2:0] a_fill;
    logic [1:0] b_fill;
    logic [0:0] c_fill;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    // show-ahead, non-power-of-two depth
    shq_fifo #(.WIDTH(8), .DEPTH(DA), .SHOW_AHEAD(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_dat(wr_dat), .wr_req(wr_req), .wr_ok(a_wok),
        .rd_dat(a_dat), .rd_req(rd_req), .rd_ok(a_rok), .fill(a_fill));

    // registered read, depth 3
    shq_fifo #(.WIDTH(8), .DEPTH(DB), .SHOW_AHEAD(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_dat(wr_dat), .wr_req(wr_req), .wr_ok(b_wok),
        .rd_dat(b_dat), .rd_req(rd_req), .rd_ok(b_rok), .fill(b_fill));

    // depth zero
    shq_fifo #(.WIDTH(8), .DEPTH(0), .SHOW_AHEAD(1'b1)) u2 (
        .clk(clk), .rst(rst), .wr_dat(wr_dat), .wr_req(wr_req), .wr_ok(c_wok),
        .rd_dat(c_dat), .rd_req(rd_req), .rd_ok(c_rok), .fill(c_fill));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        logic [7:0] qa[$];
        logic [7:0] qb[$];
        logic [7:0] regb, wseq, rexp;
        int pw, pr;
        bit wa, ra, wb, rb, in_rst;
        regb = '0; wseq = '0; rexp = '0;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            in_rst = rst;
            if (cyc > 0) begin
                // R1 / R10 / R4 on both populated configurations
                chk("R1 u0 rd_ok", int'(a_rok), int'(qa.size() > 0));
                chk("R1 u0 wr_ok", int'(a_wok), int'(qa.size() < DA));
                chk("R1 u1 rd_ok", int'(b_rok), int'(qb.size() > 0));
                chk("R1 u1 wr_ok", int'(b_wok), int'(qb.size() < DB));
                if (qa.size() == DA) chk("R10 u0 fill at full", int'(a_fill), DA);
                else                 chk("R4 u0 fill", int'(a_fill), qa.size());
                chk("R4 u1 fill", int'(b_fill), qb.size());
                if (in_rst) begin
                    chk("R5 u0 fill in reset", int'(a_fill), 0);
                    chk("R5 u0 rd_ok in reset", int'(a_rok), 0);
                end
                if (qa.size() > 0) begin
                    chk("R6 u0 head", int'(a_dat), int'(qa[0]));
                    chk("R8 u0 order", int'(a_dat), int'(rexp));
                end
                chk("R7 u1 rd_dat", int'(b_dat), int'(regb));
                chk("R9 u2 wr_ok", int'(c_wok), 0);
                chk("R9 u2 rd_ok", int'(c_rok), 0);
                chk("R9 u2 fill", int'(c_fill), 0);
            end

            // stimulus selection
            if      (cyc < 40)   begin pw = 95; pr = 5;  end  // fill past full (R2)
            else if (cyc < 80)   begin pw = 5;  pr = 95; end  // drain past empty (R3)
            else if (cyc >= 1200 && cyc < 1260) begin pw = 100; pr = 100; end
            else if (cyc >= 1600 && cyc < 1640) begin pw = 100; pr = 0; end
            else                 begin pw = 50; pr = 50; end
            rst    = (cyc < 3) || (cyc >= 1640 && cyc < 1643);
            wr_req = ($urandom_range(99) < pw);
            rd_req = ($urandom_range(99) < pr);
            wr_dat = wseq;

            @(posedge clk);
            if (rst) begin
                qa.delete(); qb.delete(); regb = '0; rexp = wseq;
            end else begin
                ra = rd_req && qa.size() > 0;
                wa = wr_req && qa.size() < DA;
                rb = rd_req && qb.size() > 0;
                wb = wr_req && qb.size() < DB;
                if (ra) begin void'(qa.pop_front()); rexp = rexp + 8'd1; end
                if (wa) begin qa.push_back(wr_dat); wseq = wseq + 8'd1; end
                if (rb) regb = qb.pop_front();
                if (wb) qb.push_back(wr_dat);
            end
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(PERIOD * (NCYC + 1000));
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end
endmodule